// File: doc/BRIEF.md
# Register-File Serial Slave With Bus Alert Response

This block is a two-wire serial bus slave that sits in front of a small byte-wide register file. A bus master writes by sending the device address, then a register pointer, then any number of data bytes that land at successive addresses. It reads by first writing the pointer, issuing a repeated start and then reading bytes, again from successive addresses, for as long as it acknowledges.

Address 0 holds eight event flags that the surrounding logic raises through single-cycle pulses. Reading address 0 clears them. Address 1 is a control register whose bits [2:1] select what the shared pin does. In alert mode, any flag event pulls an open-drain alert line low. The line stays low until the device answers an alert response read by sending its own address without losing arbitration on SDA. Bus lines are sampled through two-flop synchronizers, and the block only ever pulls SDA low.

Top module: `gauge_i2c_slave`

## Requirements
- R1: The device acknowledges only the 7-bit address 1100100 (either direction). Any other address, except the alert response address in R8, gets no acknowledge and the transfer is ignored.
- R2: In a write, the first byte after the address is loaded into the register pointer. Each later byte is acknowledged, stored at the pointer, and the pointer then increments by one.
- R3: After a pointer write and a repeated start with the read bit set, the device returns the byte at the pointer. Each byte the master acknowledges advances the pointer by one. A master NACK ends the read.
- R4: Reading any address at or above NREG (default 8) returns 00h. Writing such an address, or the read-only address 0, is acknowledged but changes nothing.
- R5: A pulse on flag_evt[i] sets status bit i at address 0. A read of address 0 returns the bits and clears them. A later pulse sets a bit again.
- R6: When control bits [2:1] equal 10b, any flag event drives alert_oe high (the alert line is pulled low) from the next clock.
- R7: With control bits [2:1] at 00b, 01b or 11b, flag events still set status but do not start an alert. An alert already active stays active across a change of those bits and across status reads.
- R8: While alerting, the device acknowledges address 0001100 with the read bit set. It then sends 1100100 followed by 0 (byte C8h), and alert_oe is released once that byte has gone out in full.
- R9: While not alerting, the alert response read is not acknowledged.
- R10: During the alert response byte, if the device leaves SDA high but samples it low at a rising SCL, it stops driving for the rest of that transfer and keeps the alert. The next alert response read is answered again.
- R11: SDA is only pulled low. sda_oe changes only while SCL is low, and never while the slave is idle.
- R12: After reset, alert_oe and sda_oe are low and the control register reads 04h (alert mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low |
| alert_oe | output | 1 | 1 pulls the alert line low |
| flag_evt | input | 8 | Event pulses, bit i sets status bit i |
| ctrl_o | output | 8 | Current control register value |

## Verification
A wrong pointer or shift state first shows up as wrong bytes on SDA within the same transfer, or as a missing acknowledge one bit time after the address byte. A broken status-clear path appears on the second read of address 0. Faults in the alert path show on alert_oe: it fails to rise a clock after an event, or it is still held after a complete response byte. A fault in arbitration shows as a corrupt byte the master sees during a contested response, or as the alert being dropped after a lost one.

// File: rtl/gauge_i2c_slave.sv
module gauge_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1100100,
  parameter int         NREG     = 8,
  parameter logic [7:0] CTRL_RST = 8'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       alert_oe,
  input  logic [7:0] flag_evt,
  output logic [7:0] ctrl_o
);
  localparam logic [6:0] ARA_ADDR = 7'b0001100;
  localparam int         AW       = $clog2(NREG);
  localparam logic [7:0] NREG8    = 8'(NREG);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_PTR, ST_WR, ST_ACK, ST_TX, ST_MACK, ST_ARA} st_t;

  st_t        state, nxt;
  logic [2:0] scl_s, sda_s;
  logic [3:0] cnt;
  logic [7:0] sh, tx, ptr, stat, rd;
  logic [7:0] rf [NREG];
  logic       oe, alert, mack_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire scl_v    = scl_s[1];
  wire sda_v    = sda_s[1];
  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start    = scl_v & sda_s[2] & ~sda_s[1];
  wire stop     = scl_v & ~sda_s[2] & sda_s[1];

  wire in_ara   = (state == ST_ARA);
  wire in_idle  = (state == ST_IDLE);
  wire load_tx  = scl_fall & (((state == ST_ACK) && (nxt == ST_TX)) || ((state == ST_MACK) && mack_ok));
  wire wr_en    = scl_fall & (state == ST_WR) & (cnt == 4'd8) & ~start & ~stop;
  wire wr_ok    = (ptr != 8'd0) && (ptr < NREG8);
  wire lost     = tx[7] & ~sda_v;
  wire ara_win  = in_ara & scl_rise & (cnt == 4'd7) & ~lost;

  always_comb begin
    rd = 8'h00;
    if (ptr == 8'd0)        rd = stat;
    else if (ptr < NREG8)   rd = rf[ptr[AW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
      oe      <= 1'b0;
      mack_ok <= 1'b0;
    end else if (start) begin
      state <= ST_ADDR;
      cnt   <= '0;
      oe    <= 1'b0;
    end else if (stop) begin
      state <= ST_IDLE;
      oe    <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WR:
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_v};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                oe    <= 1'b1;
                state <= ST_ACK;
                nxt   <= sh[0] ? ST_TX : ST_PTR;
              end else if (sh == {ARA_ADDR, 1'b1} && alert) begin
                oe    <= 1'b1;
                state <= ST_ACK;
                nxt   <= ST_ARA;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              oe    <= 1'b1;
              state <= ST_ACK;
              nxt   <= ST_WR;
              ptr   <= (state == ST_PTR) ? sh : ptr + 8'd1;
            end
          end
        ST_ACK:
          if (scl_fall) begin
            cnt   <= '0;
            state <= nxt;
            case (nxt)
              ST_TX: begin
                tx <= rd;
                oe <= ~rd[7];
              end
              ST_ARA: begin
                tx <= {DEV_ADDR, 1'b0};
                oe <= ~DEV_ADDR[6];
              end
              default: oe <= 1'b0;
            endcase
          end
        ST_TX:
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe      <= 1'b0;
              state   <= ST_MACK;
              mack_ok <= 1'b0;
            end else begin
              tx <= {tx[6:0], 1'b0};
              oe <= ~tx[6];
            end
          end
        ST_MACK:
          if (scl_rise) begin
            if (!sda_v) begin
              mack_ok <= 1'b1;
              ptr     <= ptr + 8'd1;
            end else begin
              state <= ST_IDLE;
            end
          end else if (scl_fall && mack_ok) begin
            state <= ST_TX;
            cnt   <= '0;
            tx    <= rd;
            oe    <= ~rd[7];
          end
        ST_ARA:
          if (scl_rise) begin
            if (lost) begin
              state <= ST_IDLE;
              oe    <= 1'b0;
            end else begin
              cnt <= cnt + 4'd1;
            end
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              oe    <= 1'b0;
              state <= ST_IDLE;
            end else begin
              tx <= {tx[6:0], 1'b0};
              oe <= ~tx[6];
            end
          end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'h00;
      rf[1] <= CTRL_RST;
    end else if (wr_en && wr_ok) begin
      rf[ptr[AW-1:0]] <= sh;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat <= 8'h00;
    else        stat <= ((load_tx && ptr == 8'd0) ? 8'h00 : stat) | flag_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                                  alert <= 1'b0;
    else if (|flag_evt && rf[1][2:1] == 2'b10)   alert <= 1'b1;
    else if (ara_win)                            alert <= 1'b0;

  assign sda_oe   = oe;
  assign alert_oe = alert;
  assign ctrl_o   = rf[1];
endmodule

module gauge_i2c_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       alert_oe,
  input logic [7:0] flag_evt,
  input logic [7:0] ctrl_o,
  input logic [7:0] stat,
  input logic       scl_fall,
  input logic       in_ara,
  input logic       in_idle
);
  assert_alert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_oe) |-> ($past(|flag_evt) && $past(ctrl_o[2:1]) == 2'b10));

  assert_alert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alert_oe) |-> $past(in_ara));

  assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_evt) |=> ((stat & $past(flag_evt)) == $past(flag_evt)));

  assert_sda_low_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);
endmodule

bind gauge_i2c_slave gauge_i2c_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .alert_oe (alert_oe),
  .flag_evt (flag_evt),
  .ctrl_o   (ctrl_o),
  .stat     (stat),
  .scl_fall (scl_fall),
  .in_ara   (in_ara),
  .in_idle  (in_idle)
);

// File: tb/gauge_i2c_slave_test.sv
module gauge_i2c_slave_test;
  localparam int Q = 10;
  localparam logic [7:0] AW_ = 8'hC8;
  localparam logic [7:0] AR_ = 8'hC9;
  localparam logic [7:0] ARA = 8'h19;
  localparam logic [23:0] VEC [6] = '{
    {8'h02, 8'h5A, 8'h5A},
    {8'h07, 8'h3C, 8'h3C},
    {8'h00, 8'hFF, 8'h00},
    {8'h09, 8'h77, 8'h00},
    {8'hFF, 8'h11, 8'h00},
    {8'h03, 8'hA5, 8'hA5}
  };

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_low = 0, c_low = 0;
  logic [7:0] flag_evt = 0;
  logic sda_oe, alert_oe;
  logic [7:0] ctrl_o;
  wire sda = !(sda_oe | m_low | c_low);
  int total = 0, bad = 0, viol = 0;
  logic prev_oe = 0, done = 0;

  always #2 clk = ~clk;

  gauge_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda),
    .sda_oe(sda_oe), .alert_oe(alert_oe), .flag_evt(flag_evt), .ctrl_o(ctrl_o)
  );

  always @(negedge clk) begin
    if (rst_n && m_scl && sda_oe != prev_oe) viol++;
    prev_oe <= sda_oe;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic start; m_low = 0; qw(); m_scl = 1; qw(); m_low = 1; qw(); m_scl = 0; qw(); endtask
  task automatic stop;  m_low = 1; qw(); m_scl = 1; qw(); m_low = 0; qw(); endtask

  task automatic sbit(input logic b);
    m_low = !b; qw(); m_scl = 1; qw(); m_scl = 0; qw();
  endtask

  task automatic rbit(input logic cen, input logic cb, output logic b);
    m_low = 0; c_low = cen & !cb; qw(); m_scl = 1;
    repeat (Q/2) @(negedge clk);
    b = sda;
    repeat (Q - Q/2) @(negedge clk);
    m_scl = 0; qw(); c_low = 0;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sbit(d[i]);
    rbit(1'b0, 1'b1, b);
    ack = !b;
  endtask

  task automatic rbyte(input logic ackit, input logic cen, input logic [7:0] cp, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(cen, cp[i], b);
      d[i] = b;
    end
    sbit(!ackit);
  endtask

  task automatic write1(input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    start(); wbyte(AW_, a0); wbyte(p, a1); wbyte(d, a2); stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic read1(input logic [7:0] p, output logic [7:0] d);
    logic a;
    start(); wbyte(AW_, a); wbyte(p, a); start(); wbyte(AR_, a);
    rbyte(1'b0, 1'b0, 8'h00, d); stop();
  endtask

  task automatic ara(input logic cen, input logic [7:0] cp, output logic ack, output logic [7:0] d);
    start(); wbyte(ARA, ack);
    d = 8'h00;
    if (ack) rbyte(1'b0, cen, cp, d);
    stop();
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk) flag_evt = v;
    @(negedge clk) flag_evt = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic ok, ack;
    logic [7:0] d;
    logic [7:0] b3 [3];
    repeat (5) @(negedge clk);
    chk("R12 alert at reset", {7'd0, alert_oe}, 8'd0);
    chk("R12 sda at reset", {7'd0, sda_oe}, 8'd0);
    chk("R12 ctrl port at reset", ctrl_o, 8'h04);
    rst_n = 1;
    repeat (5) @(negedge clk);
    read1(8'h01, d);
    chk("R12 ctrl read at reset", d, 8'h04);

    start(); wbyte(8'hA0, ack); stop();
    chk("R1 foreign address nack", {7'd0, ack}, 8'd0);
    start(); wbyte(AW_, ack); stop();
    chk("R1 own address ack", {7'd0, ack}, 8'd1);

    for (int i = 0; i < 6; i++) begin
      write1(VEC[i][23:16], VEC[i][15:8], ok);
      chk("R2 R4 write acked", {7'd0, ok}, 8'd1);
      read1(VEC[i][23:16], d);
      chk("R2 R4 readback", d, VEC[i][7:0]);
    end

    start(); wbyte(AW_, ack); wbyte(8'h05, ack);
    wbyte(8'hA1, ack); wbyte(8'hB2, ack); wbyte(8'hC3, ack); stop();
    chk("R2 burst last ack", {7'd0, ack}, 8'd1);
    start(); wbyte(AW_, ack); wbyte(8'h05, ack); start(); wbyte(AR_, ack);
    rbyte(1'b1, 1'b0, 8'h00, b3[0]); rbyte(1'b1, 1'b0, 8'h00, b3[1]);
    rbyte(1'b1, 1'b0, 8'h00, b3[2]); rbyte(1'b0, 1'b0, 8'h00, d); stop();
    chk("R3 burst byte 5", b3[0], 8'hA1);
    chk("R3 burst byte 6", b3[1], 8'hB2);
    chk("R3 burst byte 7", b3[2], 8'hC3);
    chk("R4 burst past end", d, 8'h00);

    ara(1'b0, 8'h00, ack, d);
    chk("R9 response read without alert", {7'd0, ack}, 8'd0);

    pulse(8'h05);
    chk("R6 alert on event", {7'd0, alert_oe}, 8'd1);
    read1(8'h00, d);
    chk("R5 status value", d, 8'h05);
    read1(8'h00, d);
    chk("R5 status cleared", d, 8'h00);
    chk("R7 alert kept after status read", {7'd0, alert_oe}, 8'd1);

    write1(8'h01, 8'h00, ok);
    chk("R7 mode now disabled", ctrl_o, 8'h00);
    chk("R7 alert kept after mode change", {7'd0, alert_oe}, 8'd1);

    ara(1'b1, 8'h80, ack, d);
    chk("R10 contested ack", {7'd0, ack}, 8'd1);
    chk("R10 bus byte after loss", d, 8'h80);
    chk("R10 alert kept after loss", {7'd0, alert_oe}, 8'd1);

    ara(1'b0, 8'h00, ack, d);
    chk("R8 response ack", {7'd0, ack}, 8'd1);
    chk("R8 response byte", d, 8'hC8);
    chk("R8 alert released", {7'd0, alert_oe}, 8'd0);
    ara(1'b0, 8'h00, ack, d);
    chk("R9 repeat response ignored", {7'd0, ack}, 8'd0);

    pulse(8'h40);
    chk("R7 no alert in disabled mode", {7'd0, alert_oe}, 8'd0);
    read1(8'h00, d);
    chk("R5 status set again", d, 8'h40);

    write1(8'h01, 8'h02, ok);
    pulse(8'h02);
    chk("R7 no alert in input mode", {7'd0, alert_oe}, 8'd0);
    write1(8'h01, 8'h04, ok);
    pulse(8'h02);
    chk("R6 alert after mode restore", {7'd0, alert_oe}, 8'd1);
    ara(1'b0, 8'h00, ack, d);
    chk("R8 second response byte", d, 8'hC8);
    chk("R8 second release", {7'd0, alert_oe}, 8'd0);

    chk("R11 sda changes while scl high", viol[7:0], 8'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule